// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder Modulo 2^n−1

This block adds two residues modulo 2^n−1, where n = DIGITS·DIGIT_BITS. It is purely combinational. Each operand and the result are held as DIGITS signed digits of radix 2^DIGIT_BITS. A digit has DIGIT_BITS ordinary bits of positive weight and one negative-weight bit, and that bit sits at the digit's lowest weight. Because the representation is redundant, the adder never propagates a carry along the word. The delay is set by one digit slice, whatever the word length.

Inside the block, each operand is regrouped. The negative bit of digit i+1 becomes the top bit of slice i. The negative bit of digit 0 is folded to weight 2^n, which is allowed because 2^n ≡ 1 modulo 2^n−1. Each slice looks at its two sign bits and its two top ordinary bits, and from these alone it picks a transfer digit for the next slice. It then forms its result digit from its own interim value and the transfer arriving from the slice below. The transfer leaving the top slice enters slice 0. The result is any valid digit pattern congruent to the sum; zero may come out as 0 or as 2^n−1. A typical use is one channel of a residue datapath, where results are fed straight back as operands and a canonical form is needed only at the exit.

Top module: `sd_mod_adder`

## Requirements
- R1: The value of the result is congruent to the sum of the operand values modulo 2^n−1. Here the value of a word is its packed ordinary bits read as an n-bit unsigned number, less 2^(i·DIGIT_BITS) for every digit i whose negative-bit port is 0.
- R2: The negative-bit ports are active low. Port bit i at 0 contributes −2^(i·DIGIT_BITS) to the value, and at 1 it contributes nothing. This holds for operands and result, digit 0 included.
- R3: Result digit j (its ordinary bits at packed positions j·DIGIT_BITS upward) depends only on operand ordinary digits j and j−1 and on operand negative bits j+1 and j (indices taken modulo DIGITS). With DIGITS=4, changing only the ordinary bits of operand digit 0 leaves result ordinary digits 2 and 3 and result negative bits 3 and 0 unchanged.
- R4: A transfer produced by the top slice is added at weight 1 of slice 0 rather than dropped. Operands whose top digits are at their maximum still give a congruent result.
- R5: Every slice result lies in [−2^DIGIT_BITS, 2^DIGIT_BITS−1], so it fits the output encoding. This includes the case where both operands have every ordinary bit set.
- R6: The case where both operands have every negative bit active and every ordinary bit clear gives a congruent result. For this case the transfer value −2 is needed.
- R7: Operands of all ordinary bits set and no negative bit active (each the value 2^n−1) give a result congruent to 0.
- R8: The block is correct for the smallest legal shape, DIGITS=2 and DIGIT_BITS=2, as well as for the larger shapes DIGITS=3, DIGIT_BITS=3 and DIGITS=4, DIGIT_BITS=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_pos | input | DIGITS*DIGIT_BITS | Ordinary bits of operand A; digit i occupies bits i·DIGIT_BITS upward |
| opa_neg_n | input | DIGITS | Negative bits of operand A, active low, bit i at weight 2^(i·DIGIT_BITS) |
| opb_pos | input | DIGITS*DIGIT_BITS | Ordinary bits of operand B |
| opb_neg_n | input | DIGITS | Negative bits of operand B, active low |
| sum_pos | output | DIGITS*DIGIT_BITS | Ordinary bits of the result |
| sum_neg_n | output | DIGITS | Negative bits of the result, active low |

## Verification
The hardest situation to reach from the ports is a slice whose two regrouped digits both sit at −2^DIGIT_BITS while the slice below also sends a negative transfer. Random stimulus almost never lines up every ordinary bit at zero with both sign bits active at neighbouring slices. The bench therefore drives all negative bits active with all ordinary bits clear on both operands, which puts every slice in that state at once and makes the wrap-around transfer negative as well. Locality is shown by changing one low digit and comparing the distant output digits before and after the change.

// File: rtl/sd_mod_adder.sv
module sd_mod_adder #(
  parameter int DIGITS     = 4,
  parameter int DIGIT_BITS = 4
) (
  input  logic [DIGITS*DIGIT_BITS-1:0] opa_pos,
  input  logic [DIGITS-1:0]            opa_neg_n,
  input  logic [DIGITS*DIGIT_BITS-1:0] opb_pos,
  input  logic [DIGITS-1:0]            opb_neg_n,
  output logic [DIGITS*DIGIT_BITS-1:0] sum_pos,
  output logic [DIGITS-1:0]            sum_neg_n
);

  localparam int N  = DIGITS * DIGIT_BITS;
  localparam int DB = DIGIT_BITS;
  localparam int W  = DIGIT_BITS + 3;

  localparam logic signed [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic signed [W-1:0] TWO  = {{(W-2){1'b0}}, 2'b10};
  localparam logic signed [W-1:0] TOP  = {3'b001, {DIGIT_BITS{1'b0}}};
  localparam logic signed [W-1:0] HALF = TOP >>> 1;
  localparam logic signed [W-1:0] LO_W = -HALF;
  localparam logic signed [W-1:0] HI_W = TOP - TWO;
  localparam logic signed [W-1:0] LO_R = -TOP;
  localparam logic signed [W-1:0] HI_R = TOP - ONE;

  // transfer leaving slice g sits at bits [2g+1:2g], two's complement in [-2,1]
  logic [2*DIGITS-1:0] xfer_bus;

  for (genvar g = 0; g < DIGITS; g++) begin : g_slice
    localparam int NX = (g + 1) % DIGITS;
    localparam int PV = (g + DIGITS - 1) % DIGITS;

    logic [1:0]          nact, mset;
    logic signed [3:0]   coarse;
    logic signed [1:0]   t_out;
    logic signed [W-1:0] va, vb, t_ext, tin_ext, w, r;

    assign nact   = {1'b0, ~opa_neg_n[NX]} + {1'b0, ~opb_neg_n[NX]};
    assign mset   = {1'b0, opa_pos[g*DB+DB-1]} + {1'b0, opb_pos[g*DB+DB-1]};
    assign coarse = $signed({2'b00, mset}) - $signed({1'b0, nact, 1'b0});

    always_comb begin
      if (coarse == -4'sd4)      t_out = 2'sb10;
      else if (coarse <= -4'sd2) t_out = 2'sb11;
      else if (coarse <= 4'sd0)  t_out = 2'sb00;
      else                       t_out = 2'sb01;
    end

    assign xfer_bus[2*g +: 2] = t_out;

    assign va = $signed({3'b000, opa_pos[g*DB +: DB]}) - (opa_neg_n[NX] ? '0 : TOP);
    assign vb = $signed({3'b000, opb_pos[g*DB +: DB]}) - (opb_neg_n[NX] ? '0 : TOP);

    assign t_ext   = {{(W-2){t_out[1]}}, t_out};
    assign tin_ext = {{(W-2){xfer_bus[2*PV+1]}}, xfer_bus[2*PV +: 2]};

    assign w = va + vb - (t_ext <<< DIGIT_BITS);
    assign r = w + tin_ext;

    assign sum_pos[g*DB +: DB] = r[DB-1:0];
    assign sum_neg_n[NX]       = ~r[W-1];

    always_comb begin
      // R3
      interim_range_chk: assert (w >= LO_W && w <= HI_W)
        else $error("interim value out of window in slice %0d", g);
      // R5
      digit_range_chk: assert (r >= LO_R && r <= HI_R)
        else $error("slice %0d result outside digit range", g);
      // R6
      xfer_sign_chk: assert ((t_out >= 2'sb00 || nact != 2'b00) &&
                             (t_out != 2'sb01 || mset != 2'b00))
        else $error("transfer sign not backed by top bits in slice %0d", g);
    end
  end

  if (N <= 60) begin : g_residue
    always_comb begin
      longint m;
      longint acc;
      m   = (longint'(1) << N) - 1;
      acc = 0;
      for (int b = 0; b < N; b++) begin
        if (opa_pos[b]) acc += longint'(1) << b;
        if (opb_pos[b]) acc += longint'(1) << b;
        if (sum_pos[b]) acc -= longint'(1) << b;
      end
      for (int i = 0; i < DIGITS; i++) begin
        if (!opa_neg_n[i]) acc -= longint'(1) << (i*DB);
        if (!opb_neg_n[i]) acc -= longint'(1) << (i*DB);
        if (!sum_neg_n[i]) acc += longint'(1) << (i*DB);
      end
      // R1
      residue_chk: assert (acc % m == 0)
        else $error("result not congruent to operand sum");
    end
  end

endmodule

// File: tb/test_sd_mod_adder.sv
`timescale 1ns/1ps
module test_sd_mod_adder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [3:0]  a2p, b2p, s2p;  logic [1:0] a2n, b2n, s2n;
  logic [8:0]  a3p, b3p, s3p;  logic [2:0] a3n, b3n, s3n;
  logic [15:0] a4p, b4p, s4p;  logic [3:0] a4n, b4n, s4n;

  sd_mod_adder #(.DIGITS(2), .DIGIT_BITS(2)) i_sd_mod_adder_min (
    .opa_pos(a2p), .opa_neg_n(a2n), .opb_pos(b2p), .opb_neg_n(b2n),
    .sum_pos(s2p), .sum_neg_n(s2n));
  sd_mod_adder #(.DIGITS(3), .DIGIT_BITS(3)) i_sd_mod_adder (
    .opa_pos(a3p), .opa_neg_n(a3n), .opb_pos(b3p), .opb_neg_n(b3n),
    .sum_pos(s3p), .sum_neg_n(s3n));
  sd_mod_adder #(.DIGITS(4), .DIGIT_BITS(4)) i_sd_mod_adder_wide (
    .opa_pos(a4p), .opa_neg_n(a4n), .opb_pos(b4p), .opb_neg_n(b4n),
    .sum_pos(s4p), .sum_neg_n(s4n));

  // shape sel: DIGITS = DIGIT_BITS = sel
  function automatic longint decode(input logic [15:0] p, input logic [3:0] ng, input int sel);
    longint v = 0;
    for (int b = 0; b < sel*sel; b++) if (p[b]) v += longint'(1) << b;
    for (int i = 0; i < sel; i++) if (!ng[i]) v -= longint'(1) << (i*sel);
    return v;
  endfunction

  function automatic longint md(input longint v, input int sel);
    longint m = (longint'(1) << (sel*sel)) - 1;
    return ((v % m) + m) % m;
  endfunction

  function automatic logic [15:0] pmask(input int sel);
    return 16'((32'd1 << (sel*sel)) - 1);
  endfunction

  task automatic apply(input int sel, input logic [15:0] ap, input logic [3:0] an,
                       input logic [15:0] bp, input logic [3:0] bn,
                       output logic [15:0] sp, output logic [3:0] sn);
    @(negedge clk);
    a2p = ap[3:0]; a2n = an[1:0]; b2p = bp[3:0]; b2n = bn[1:0];
    a3p = ap[8:0]; a3n = an[2:0]; b3p = bp[8:0]; b3n = bn[2:0];
    a4p = ap;      a4n = an;      b4p = bp;      b4n = bn;
    #1;
    case (sel)
      2:       begin sp = {12'd0, s2p}; sn = {2'b11, s2n}; end
      3:       begin sp = {7'd0, s3p};  sn = {1'b1, s3n};  end
      default: begin sp = s4p;          sn = s4n;          end
    endcase
  endtask

  task automatic check_sum(input int sel, input logic [15:0] ap, input logic [3:0] an,
                           input logic [15:0] bp, input logic [3:0] bn, input string req);
    logic [15:0] sp;
    logic [3:0]  sn;
    longint got, exp;
    apply(sel, ap, an, bp, bn, sp, sn);
    got = md(decode(sp, sn, sel), sel);
    exp = md(decode(ap, an, sel) + decode(bp, bn, sel), sel);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s (shape %0d): residue got %0d expected %0d", req, sel, got, exp);
    end
  endtask

  // R1: zero operands after start-up give a zero residue
  task automatic t_zero();
    for (int s = 2; s <= 4; s++) check_sum(s, 16'd0, 4'hF, 16'd0, 4'hF, "R1 zero");
  endtask

  // R2: single active negative bit weights, digit 0 and digit 1
  task automatic t_neg_weights();
    for (int s = 3; s <= 4; s++) begin
      check_sum(s, 16'd0, 4'hE, 16'd0, 4'hF, "R2 neg digit0");
      check_sum(s, 16'd0, 4'hD, 16'd5, 4'hF, "R2 neg digit1");
      check_sum(s, 16'd3, 4'hF, 16'd0, 4'hE, "R2 neg on B");
    end
  endtask

  // R4: top digits at maximum force a transfer out of the top slice
  task automatic t_end_around();
    for (int s = 2; s <= 4; s++) begin
      logic [15:0] topd;
      topd = pmask(s) & ~16'((32'd1 << ((s-1)*s)) - 1);
      check_sum(s, topd, 4'hF, topd, 4'hF, "R4 top transfer");
      check_sum(s, topd | 16'd1, 4'hF, topd, 4'hF, "R4 top transfer plus one");
    end
  endtask

  // R6: every negative bit active, ordinary bits clear, on both operands
  task automatic t_all_neg();
    for (int s = 2; s <= 4; s++) begin
      check_sum(s, 16'd0, 4'h0, 16'd0, 4'h0, "R6 all negative");
      check_sum(s, 16'd1, 4'h0, 16'd0, 4'h0, "R6 near all negative");
    end
  endtask

  // R7 and R5: all ordinary bits set, no negative bits
  task automatic t_all_pos();
    for (int s = 2; s <= 4; s++) begin
      logic [15:0] sp;
      logic [3:0]  sn;
      longint got;
      apply(s, pmask(s), 4'hF, pmask(s), 4'hF, sp, sn);
      got = md(decode(sp, sn, s), s);
      checks++;
      if (got != 0) begin
        errors++;
        $display("FAIL R7 (shape %0d): residue got %0d expected 0", s, got);
      end
      check_sum(s, pmask(s), 4'hF, pmask(s), 4'h0, "R5 full posibits mixed");
    end
  endtask

  // R1 and R8: random operands on every shape
  task automatic t_random();
    for (int s = 2; s <= 4; s++) begin
      for (int n = 0; n < 60; n++) begin
        logic [15:0] ap, bp;
        logic [3:0]  an, bn;
        ap = 16'($urandom) & pmask(s);
        bp = 16'($urandom) & pmask(s);
        an = 4'($urandom);
        bn = 4'($urandom);
        check_sum(s, ap, an, bp, bn, (s == 2) ? "R8 smallest shape" : "R1 random");
      end
    end
  endtask

  // R3: changing digit 0 ordinary bits leaves distant output digits alone
  task automatic t_locality();
    for (int n = 0; n < 25; n++) begin
      logic [15:0] ap, bp, sp0, sp1;
      logic [3:0]  an, bn, sn0, sn1;
      ap = 16'($urandom);
      bp = 16'($urandom);
      an = 4'($urandom);
      bn = 4'($urandom);
      apply(4, ap, an, bp, bn, sp0, sn0);
      ap[3:0] = 4'($urandom);
      bp[3:0] = ~bp[3:0];
      apply(4, ap, an, bp, bn, sp1, sn1);
      checks++;
      if (sp1[15:8] != sp0[15:8] || sn1[3] != sn0[3] || sn1[0] != sn0[0]) begin
        errors++;
        $display("FAIL R3 locality: got %h/%b expected %h/%b",
                 sp1[15:8], {sn1[3], sn1[0]}, sp0[15:8], {sn0[3], sn0[0]});
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: finished 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a2p = '0; a2n = '1; b2p = '0; b2n = '1;
    a3p = '0; a3n = '1; b3p = '0; b3n = '1;
    a4p = '0; a4n = '1; b4p = '0; b4n = '1;
    repeat (2) @(negedge clk);
    t_zero();
    t_neg_weights();
    t_end_around();
    t_all_neg();
    t_all_pos();
    t_random();
    t_locality();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule